// File: doc/BRIEF.md
# Descriptor Ring Queue Manager

This block keeps the producer and consumer bookkeeping for a circular queue of work descriptors held in memory. Software chooses the entry size and the number of ring slots. It then moves the queue forward by writing counts rather than pointers. Writing a count to the post register makes that many new entries available. Writing a count to the release register retires that many finished entries.

Internally the block keeps three wrapping indices: the allocation (write) index, the dispatch index that is offered to the execution engine, and the retire index of the oldest finished entry. It also keeps three counters: entries available but not dispatched, entries in flight, and entries finished but not released. The engine takes an index with a valid/ready handshake and reports completion with a one-cycle done strobe. A halt register stops dispatch. Status words return the packed finished count with the retire index, the allocation index, and two sticky error flags.

Register addresses (3 bits): 0 ring size, 1 entry-size mode, 2 post count, 3 release count, 4 halt, 5 finished status, 6 allocation status, 7 error flags. Addresses 2 and 3 read as zero.

Top module: `desc_ring_qmgr`

## Requirements
- R1: After reset the ring size reads 1024, the mode reads 7, the halt register reads 1, the error flags read 0, every index and counter is 0, and no index is offered to the engine.
- R2: A post write of N that fits advances the allocation index by N modulo the ring size; the allocation status word carries that index in bits [31:16], with zeros elsewhere, and a post of 0 changes nothing.
- R3: A post write is rejected, leaving every index and counter unchanged, when available plus in-flight plus finished plus N would exceed the ring size; this sets error flag bit 1, which stays set until reset.
- R4: The engine is offered an index (valid high) only while the available count is nonzero and the block is not halted; the offered index starts at 0, advances by one on each valid and ready cycle, and wraps to 0 at the ring size.
- R5: Writing 1 in bit 0 of the halt register stops dispatch from the next cycle, and writing 0 resumes it; the register reads back in bit 0.
- R6: Each done strobe seen while at least one entry is in flight adds one to the finished count; a done strobe with nothing in flight is ignored.
- R7: A release write of N no larger than the finished count lowers that count by N and advances the retire index by N modulo the ring size; the finished status word holds the count in bits [14:0] and the retire index in bits [28:16].
- R8: A release write larger than the finished count is clamped to that count and sets error flag bit 0, which stays set until reset.
- R9: Mode value 1 (32-byte entries) allows up to min(2^14, 2^IDX_W) slots, which is 8192 by default; mode value 7 (128-byte entries) allows up to 4096 slots. Mode writes of any other value are ignored. A ring size write of 0 is ignored, and a larger write is clamped to the current mode's limit. A mode change also clamps the current size.
- R10: Every accepted ring size or mode write sets all indices and counters back to 0 and keeps the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Register write address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 3 | Register read address |
| reg_rdata_o | output | 32 | Register read data, combinational |
| disp_valid_o | output | 1 | An index is offered to the engine |
| disp_idx_o | output | IDX_W | Offered ring index |
| disp_ready_i | input | 1 | Engine accepts the offered index |
| done_i | input | 1 | Engine finished one entry |

## Verification
The assertions check on every cycle the properties that follow from the counters and pointers together. The three counters never total more than the ring size. The distance from the retire index to the allocation index always equals that total modulo the size. Every pointer step and every offered index stays inside the ring. The overflow flag is sticky, an oversized release empties the finished count, and a halt write removes valid on the next cycle. Only the bench scenarios can show the actual wrap points, the clamping of ring size and mode writes, the rejection and ignore cases seen at the ports, and the packed layout of the status words.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [2:0] {
    A_SIZE  = 3'd0,
    A_MODE  = 3'd1,
    A_ADD   = 3'd2,
    A_REL   = 3'd3,
    A_HALT  = 3'd4,
    A_DONE  = 3'd5,
    A_ALLOC = 3'd6,
    A_ERR   = 3'd7
  } qm_reg_e;

  localparam logic [2:0] MODE_SMALL = 3'd1;
  localparam logic [2:0] MODE_LARGE = 3'd7;
endpackage

// File: rtl/qm_ptr.sv
module qm_ptr #(
  parameter int IDX_W = 13,
  parameter int SZ_W  = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SZ_W-1:0]  step_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [SZ_W:0]    sum, nxt;

  // step never exceeds size, so one subtraction is enough to wrap
  always_comb begin
    sum = (SZ_W+1)'(ptr_q) + (SZ_W+1)'(step_i);
    nxt = (sum >= (SZ_W+1)'(size_i)) ? sum - (SZ_W+1)'(size_i) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else            ptr_q <= nxt[IDX_W-1:0];
  end

  assign ptr_o = ptr_q;

  p_step_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> step_i <= size_i);
  p_ptr_in_ring_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SZ_W)'(ptr_q) < size_i);
endmodule

// File: rtl/desc_ring_qmgr.sv
module desc_ring_qmgr
  import qm_pkg::*;
#(
  parameter int IDX_W    = 13,
  parameter int DEF_RING = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_waddr_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic [2:0]       reg_raddr_i,
  output logic [31:0]      reg_rdata_o,
  output logic             disp_valid_o,
  output logic [IDX_W-1:0] disp_idx_o,
  input  logic             disp_ready_i,
  input  logic             done_i
);
  localparam int SZ_W  = IDX_W + 1;
  localparam int LIM_S = (IDX_W >= 14) ? (1 << 14) : (1 << IDX_W);
  localparam int LIM_L = (IDX_W >= 12) ? (1 << 12) : (1 << IDX_W);
  localparam int NPTR  = 3;  // 0 alloc, 1 dispatch, 2 retire

  logic [SZ_W-1:0]  size_q, limit, new_lim;
  logic [2:0]       mode_q;
  logic             halt_q;
  logic [1:0]       err_q;
  logic [SZ_W-1:0]  avail_q, infl_q, pend_q;
  logic [SZ_W+1:0]  occ;
  logic [33:0]      add_sum;
  logic             wr_size, wr_mode, wr_add, wr_rel, wr_halt;
  logic             size_ok, mode_ok, clr;
  logic             add_ok, add_bad, rel_big, fire, done_ok;
  logic [SZ_W-1:0]  add_n, rel_n;
  logic [SZ_W-1:0]  steps [NPTR];
  logic [IDX_W-1:0] ptrs  [NPTR];

  always_comb begin
    wr_size = reg_we_i && (reg_waddr_i == A_SIZE);
    wr_mode = reg_we_i && (reg_waddr_i == A_MODE);
    wr_add  = reg_we_i && (reg_waddr_i == A_ADD);
    wr_rel  = reg_we_i && (reg_waddr_i == A_REL);
    wr_halt = reg_we_i && (reg_waddr_i == A_HALT);
    size_ok = wr_size && (reg_wdata_i != 32'd0);
    mode_ok = wr_mode && ((reg_wdata_i == {29'd0, MODE_SMALL}) ||
                          (reg_wdata_i == {29'd0, MODE_LARGE}));
    clr     = size_ok || mode_ok;
    limit   = (mode_q == MODE_SMALL) ? SZ_W'(LIM_S) : SZ_W'(LIM_L);
    new_lim = (reg_wdata_i[2:0] == MODE_SMALL) ? SZ_W'(LIM_S) : SZ_W'(LIM_L);
    occ     = (SZ_W+2)'(avail_q) + (SZ_W+2)'(infl_q) + (SZ_W+2)'(pend_q);
    add_sum = 34'(occ) + 34'(reg_wdata_i);
    add_ok  = wr_add && (add_sum <= 34'(size_q));
    add_bad = wr_add && !add_ok;
    add_n   = add_ok ? reg_wdata_i[SZ_W-1:0] : '0;
    rel_big = 32'(pend_q) < reg_wdata_i;
    rel_n   = !wr_rel ? '0 : (rel_big ? pend_q : reg_wdata_i[SZ_W-1:0]);
    fire    = disp_valid_o && disp_ready_i;
    done_ok = done_i && (infl_q != '0);
  end

  assign steps[0] = add_n;
  assign steps[1] = SZ_W'(fire);
  assign steps[2] = rel_n;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    qm_ptr #(.IDX_W(IDX_W), .SZ_W(SZ_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .step_i (steps[g]),
      .size_i (size_q),
      .ptr_o  (ptrs[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= SZ_W'(DEF_RING);
      mode_q <= MODE_LARGE;
      halt_q <= 1'b1;
      err_q  <= '0;
    end else begin
      if (size_ok)
        size_q <= (reg_wdata_i > 32'(limit)) ? limit : reg_wdata_i[SZ_W-1:0];
      else if (mode_ok) begin
        mode_q <= reg_wdata_i[2:0];
        if (size_q > new_lim) size_q <= new_lim;
      end
      if (wr_halt) halt_q <= reg_wdata_i[0];
      if (wr_rel && rel_big) err_q[0] <= 1'b1;
      if (add_bad) err_q[1] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= '0;
      infl_q  <= '0;
      pend_q  <= '0;
    end else if (clr) begin
      avail_q <= '0;
      infl_q  <= '0;
      pend_q  <= '0;
    end else begin
      avail_q <= avail_q + add_n - SZ_W'(fire);
      infl_q  <= infl_q + SZ_W'(fire) - SZ_W'(done_ok);
      pend_q  <= pend_q + SZ_W'(done_ok) - rel_n;
    end
  end

  assign disp_valid_o = !halt_q && (avail_q != '0);
  assign disp_idx_o   = ptrs[1];

  always_comb begin
    reg_rdata_o = '0;
    case (reg_raddr_i)
      A_SIZE:  reg_rdata_o = 32'(size_q);
      A_MODE:  reg_rdata_o = 32'(mode_q);
      A_HALT:  reg_rdata_o = 32'(halt_q);
      A_DONE: begin
        reg_rdata_o[14:0]  = 15'(pend_q);
        reg_rdata_o[28:16] = 13'(ptrs[2]);
      end
      A_ALLOC: reg_rdata_o[31:16] = 16'(ptrs[0]);
      A_ERR:   reg_rdata_o = 32'(err_q);
      default: reg_rdata_o = '0;
    endcase
  end

  // distance from retire to alloc pointer, checked against the counters
  logic [SZ_W+1:0] gap, occ_mod;
  always_comb begin
    if (ptrs[0] >= ptrs[2])
      gap = (SZ_W+2)'(ptrs[0]) - (SZ_W+2)'(ptrs[2]);
    else
      gap = (SZ_W+2)'(ptrs[0]) + (SZ_W+2)'(size_q) - (SZ_W+2)'(ptrs[2]);
    occ_mod = (occ == (SZ_W+2)'(size_q)) ? '0 : occ;
  end

  p_occ_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= (SZ_W+2)'(size_q));
  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q[1] |=> err_q[1]);
  p_ptr_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap == occ_mod);
  p_idx_in_ring_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (SZ_W)'(disp_idx_o) < size_q);
  p_halt_stops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_halt && reg_wdata_i[0]) |=> !disp_valid_o);
  p_rel_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rel && rel_big && !done_i) |=> pend_q == '0);
  p_stray_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && infl_q == '0 && !reg_we_i) |=> $stable(pend_q));
endmodule

// File: tb/desc_ring_qmgr_tb_top.sv
module desc_ring_qmgr_tb_top;
  import qm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 13;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             we = 1'b0;
  logic [2:0]       waddr = '0;
  logic [31:0]      wdata = '0;
  logic [2:0]       raddr = '0;
  logic [31:0]      rdata;
  logic             dvalid;
  logic [IDX_W-1:0] didx;
  logic             dready = 1'b0;
  logic             done = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_qmgr #(.IDX_W(IDX_W), .DEF_RING(1024)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .disp_valid_o(dvalid), .disp_idx_o(didx), .disp_ready_i(dready),
    .done_i(done)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_SIZE,  32'd0,    A_ALLOC, 32'h0000_0000, 4'd1},  // R1
    '{1'b0, A_SIZE,  32'd0,    A_HALT,  32'd1,         4'd1},  // R1
    '{1'b0, A_SIZE,  32'd0,    A_SIZE,  32'd1024,      4'd1},  // R1
    '{1'b0, A_SIZE,  32'd0,    A_MODE,  32'd7,         4'd1},  // R1
    '{1'b1, A_ADD,   32'd5,    A_ALLOC, 32'h0005_0000, 4'd2},  // R2
    '{1'b1, A_ADD,   32'd1020, A_ERR,   32'd2,         4'd3},  // R3 overfill
    '{1'b1, A_ADD,   32'd0,    A_ALLOC, 32'h0005_0000, 4'd2},  // R2 zero post
    '{1'b1, A_REL,   32'd3,    A_ERR,   32'd3,         4'd8},  // R8 clamp
    '{1'b0, A_SIZE,  32'd0,    A_DONE,  32'd0,         4'd8},  // R8 nothing moved
    '{1'b1, A_ADD,   32'd1019, A_ALLOC, 32'h0000_0000, 4'd2},  // R2 wrap at 1024
    '{1'b1, A_ADD,   32'd1,    A_ALLOC, 32'h0000_0000, 4'd3},  // R3 full ring
    '{1'b1, A_MODE,  32'd3,    A_MODE,  32'd7,         4'd9},  // R9 bad mode
    '{1'b1, A_SIZE,  32'd5000, A_SIZE,  32'd4096,      4'd9},  // R9 clamp large
    '{1'b1, A_ADD,   32'd4000, A_ALLOC, 32'h0FA0_0000, 4'd10}, // R10 reinit
    '{1'b1, A_MODE,  32'd1,    A_MODE,  32'd1,         4'd9},  // R9
    '{1'b1, A_SIZE,  32'd0,    A_SIZE,  32'd4096,      4'd9},  // R9 zero size
    '{1'b1, A_SIZE,  32'd9000, A_SIZE,  32'd8192,      4'd9},  // R9 clamp small
    '{1'b1, A_ADD,   32'd8192, A_ALLOC, 32'h0000_0000, 4'd2},  // R2 full wrap
    '{1'b1, A_SIZE,  32'd8,    A_ALLOC, 32'h0000_0000, 4'd10}, // R10
    '{1'b1, A_ADD,   32'd6,    A_ALLOC, 32'h0006_0000, 4'd2}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    raddr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse_done(input int n);
    @(negedge clk);
    done = 1'b1;
    repeat (n) @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid", 32'(dvalid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, v);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp);
    end

    // ring 8, six posted, halted
    chk("R5 halted", 32'(dvalid), 32'd0);
    dready = 1'b1;
    wr(A_HALT, 32'd0);
    for (int k = 0; k < 6; k++) begin
      chk("R4 valid", 32'(dvalid), 32'd1);
      chk("R4 idx", 32'(didx), 32'(k));
      @(negedge clk);
    end
    chk("R4 drained", 32'(dvalid), 32'd0);
    dready = 1'b0;

    pulse_done(6);
    rd(A_DONE, v); chk("R6 count", v, 32'd6);
    wr(A_REL, 32'd4);
    rd(A_DONE, v); chk("R7 release", v, 32'h0004_0002);
    wr(A_ADD, 32'd6);
    rd(A_ALLOC, v); chk("R2 wrap", v, 32'h0004_0000);
    wr(A_ADD, 32'd1);
    rd(A_ALLOC, v); chk("R3 reject", v, 32'h0004_0000);

    wr(A_HALT, 32'd1);
    chk("R5 stop", 32'(dvalid), 32'd0);
    rd(A_HALT, v); chk("R5 read", v, 32'd1);
    wr(A_HALT, 32'd0);
    chk("R5 resume", 32'(dvalid), 32'd1);

    dready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      chk("R4 wrap idx", 32'(didx), 32'((6 + k) % 8));
      @(negedge clk);
    end
    dready = 1'b0;
    chk("R4 empty", 32'(dvalid), 32'd0);

    pulse_done(6);
    pulse_done(1);
    rd(A_DONE, v); chk("R6 stray done", v, 32'h0004_0008);
    wr(A_REL, 32'd8);
    rd(A_DONE, v); chk("R7 wrap", v, 32'h0004_0000);
    rd(A_ERR, v); chk("R8 sticky", v, 32'd3);

    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    rd(A_ERR, v);  chk("R1 err", v, 32'd0);
    rd(A_SIZE, v); chk("R1 size", v, 32'd1024);
    rd(A_HALT, v); chk("R1 halt", v, 32'd1);
    rd(A_DONE, v); chk("R1 done", v, 32'd0);
    chk("R1 no offer", 32'(dvalid), 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule